// File: doc/BRIEF.md
# Host DMA Request and Interrupt Generator

This block drives the host-side DMA request for data moved through the adapter's data FIFO. It also drives the single host interrupt line. The host sets a DMA enable, a direction, two interrupt enables, a burst bit and a single-cycle mode bit. From these bits and the state of the FIFO, the block raises the request and keeps it active in demand mode.

In demand mode the request stays active until one of four things happens: the transfer ends, the FIFO cannot accept or supply another word, the host disables DMA, or nine transfers have completed since the last pause. In that last case the request is withheld for one host cycle so the host can refresh its memory, unless burst is set. In single-cycle mode the request is withheld for one cycle after every acknowledged transfer, and the burst bit plays no part.

A completion flag sets when the host signals terminal count on an acknowledged transfer. The flag stays set until DMA enable is cleared. The gated completion flag and the gated "command full" flag from the mailbox are ORed onto one interrupt line. The request and interrupt outputs each come with an output-enable, so the lines can float and be shared with other cards.

Top module: `host_dma_req`

## Requirements
- R1: While `dma_en` is 0, `drq_oe` is 0 and `drq` is 0. While `dma_en` is 1, `drq_oe` is 1.
- R2: In demand mode (`single_mode`=0) with the FIFO ready and `done`=0, `drq` stays 1 across up to eight back-to-back acknowledged transfers.
- R3: In demand mode with `burst`=0, the ninth acknowledged transfer since the last restart is followed by exactly one cycle with `drq`=0. The request then resumes, and the count restarts.
- R4: In demand mode with `burst`=1, `drq` never pauses on account of the transfer count.
- R5: The FIFO gate depends on `dir`. With `dir`=0 (host to adapter), `drq` is 0 while `fifo_full`=1 and `fifo_empty` has no effect. With `dir`=1 (adapter to host), `drq` is 0 while `fifo_empty`=1 and `fifo_full` has no effect.
- R6: With `single_mode`=1, each acknowledged transfer is followed by one cycle with `drq`=0, whatever the value of `burst`.
- R7: An acknowledged transfer with `tc`=1 sets `done` in the next cycle. While `done`=1, `drq` is 0.
- R8: `done` stays 1 as long as `dma_en` is 1. It clears in the cycle after `dma_en` goes to 0.
- R9: `irq` = (`done` AND `tc_ie`) OR (`cmd_full` AND `cmd_ie`). `irq_oe` = `tc_ie` OR `cmd_ie`, so the line floats when both enables are 0.
- R10: After reset, `done` is 0 and `drq` is 0.
- R11: The nine-transfer count restarts whenever the FIFO gate drops the request or `dma_en` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Active-low reset |
| dma_en | input | 1 | DMA enable |
| dir | input | 1 | 0 = host to adapter, 1 = adapter to host |
| tc_ie | input | 1 | Terminal-count interrupt enable |
| cmd_ie | input | 1 | Command-full interrupt enable |
| burst | input | 1 | Suppress the refresh pause |
| single_mode | input | 1 | 1 = single-cycle mode, 0 = demand mode |
| fifo_full | input | 1 | Data FIFO full |
| fifo_empty | input | 1 | Data FIFO empty |
| dack | input | 1 | Host DMA acknowledge, one transfer per cycle |
| tc | input | 1 | Host terminal count |
| cmd_full | input | 1 | Mailbox holds a command for the host |
| drq | output | 1 | DMA request value |
| drq_oe | output | 1 | Output enable for the request line |
| irq | output | 1 | Host interrupt value |
| irq_oe | output | 1 | Output enable for the interrupt line |
| done | output | 1 | Transfer completed |

## Verification
The bench uses the default `PAUSE_EVERY` of 9, so the refresh pause lands at cycle index 9 of a run in which the host acknowledges every request. The bench counts the cycles in which the request is low in runs of 10 to 20 cycles. At this size, the bench can reach the second pause and the restart of the count after a FIFO stall or a disable, as well as the alternating pattern of single-cycle mode.

// File: rtl/host_dma_req.sv
module host_dma_req #(
  parameter int PAUSE_EVERY = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic dir,
  input  logic tc_ie,
  input  logic cmd_ie,
  input  logic burst,
  input  logic single_mode,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic dack,
  input  logic tc,
  input  logic cmd_full,
  output logic drq,
  output logic drq_oe,
  output logic irq,
  output logic irq_oe,
  output logic done
);
  localparam int CW = $clog2(PAUSE_EVERY + 1);
  localparam logic [CW-1:0] LAST = CW'(PAUSE_EVERY - 1);

  logic [CW-1:0] cnt;
  logic gap;
  logic fifo_ok, xfer, last_xfer, gap_set;

  assign fifo_ok   = dir ? !fifo_empty : !fifo_full;
  assign drq       = dma_en && !done && fifo_ok && !gap;
  assign xfer      = drq && dack;
  assign last_xfer = xfer && !single_mode && cnt == LAST;
  assign gap_set   = xfer && (single_mode || (last_xfer && !burst));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      gap  <= 1'b0;
      done <= 1'b0;
    end else begin
      gap  <= gap_set;
      done <= dma_en && (done || (xfer && tc));
      if (!dma_en || !fifo_ok || last_xfer || single_mode)
        cnt <= '0;
      else if (xfer)
        cnt <= cnt + 1'b1;
    end
  end

  assign drq_oe = dma_en;
  assign irq_oe = tc_ie || cmd_ie;
  assign irq    = (done && tc_ie) || (cmd_full && cmd_ie);
endmodule

module host_dma_req_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_en,
  input logic dir,
  input logic tc_ie,
  input logic cmd_ie,
  input logic burst,
  input logic single_mode,
  input logic fifo_full,
  input logic fifo_empty,
  input logic dack,
  input logic tc,
  input logic cmd_full,
  input logic drq,
  input logic drq_oe,
  input logic irq,
  input logic irq_oe,
  input logic done
);
  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> (!drq && !drq_oe));
  p_fifo_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir && fifo_empty) || (!dir && fifo_full)) |-> !drq);
  p_single_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && drq && dack) |=> !drq);
  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && drq && dack && tc) |=> done);
  p_done_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drq);
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dma_en) |=> done);
  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !done);
  p_irq_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_ie && !cmd_ie) |-> (!irq_oe && !irq));
endmodule

bind host_dma_req host_dma_req_chk u_chk (.*);

// File: tb/sim_host_dma_req.sv
module sim_host_dma_req;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 0, dir = 0, tc_ie = 0, cmd_ie = 0, burst = 0, single_mode = 0;
  logic fifo_full = 0, fifo_empty = 0, dack = 0, tc = 0, cmd_full = 0;
  logic drq, drq_oe, irq, irq_oe, done;
  int checks = 0, errors = 0;
  int lows, first_low;

  always #5 clk = ~clk;

  host_dma_req u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // host acknowledges whenever the request is up, for n cycles
  task automatic follow(input int n);
    lows = 0; first_low = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!drq) begin lows++; if (first_low < 0) first_low = i; end
      dack = drq;
    end
    @(negedge clk);
    dack = 0;
  endtask

  task automatic restart();
    @(negedge clk);
    dack = 0; tc = 0; dma_en = 0; burst = 0; single_mode = 0;
    fifo_full = 0; fifo_empty = 0; dir = 0;
    @(negedge clk);
    dma_en = 1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 done", done, 0);
    check("R10 drq", drq, 0);
    check("R1 drq_oe off", drq_oe, 0);
  endtask

  task automatic t_demand_pause();
    restart();
    check("R1 drq_oe on", drq_oe, 1);
    follow(20);
    check("R2 first low index", first_low, 9);
    check("R3 one-cycle pauses in 20", lows, 2);
  endtask

  task automatic t_burst();
    restart();
    burst = 1;
    follow(20);
    check("R4 no pause with burst", lows, 0);
  endtask

  task automatic t_single();
    restart();
    single_mode = 1; burst = 1;
    follow(10);
    check("R6 alternating lows", lows, 5);
    check("R6 first low", first_low, 1);
  endtask

  task automatic t_fifo();
    restart();
    follow(5);
    @(negedge clk); fifo_full = 1; fifo_empty = 0;
    @(negedge clk); check("R5 download full gates", drq, 0);
    fifo_full = 0; fifo_empty = 1;
    @(negedge clk); check("R5 download ignores empty", drq, 1);
    fifo_empty = 0;
    follow(12);
    check("R11 restart after fifo stall", first_low, 9);
    restart();
    dir = 1; fifo_full = 1;
    @(negedge clk); check("R5 upload ignores full", drq, 1);
    fifo_full = 0; fifo_empty = 1;
    @(negedge clk); check("R5 upload empty gates", drq, 0);
    fifo_empty = 0;
  endtask

  task automatic t_disable_restart();
    restart();
    follow(5);
    restart();
    follow(12);
    check("R11 restart after disable", first_low, 9);
  endtask

  task automatic t_done_irq();
    restart();
    tc_ie = 0; cmd_ie = 0;
    @(negedge clk);
    check("R9 irq_oe float", irq_oe, 0);
    dack = 1; tc = 1;
    @(negedge clk);
    dack = 0; tc = 0;
    check("R7 done set", done, 1);
    check("R7 drq off when done", drq, 0);
    check("R9 irq gated off", irq, 0);
    tc_ie = 1;
    repeat (4) @(negedge clk);
    check("R8 done sticky", done, 1);
    check("R9 irq from done", irq, 1);
    check("R9 irq_oe", irq_oe, 1);
    dma_en = 0;
    @(negedge clk);
    check("R8 done cleared", done, 0);
    check("R9 irq clears with done", irq, 0);
    tc_ie = 0; cmd_ie = 1; cmd_full = 1;
    @(negedge clk);
    check("R9 irq from cmd_full", irq, 1);
    cmd_ie = 0;
    @(negedge clk);
    check("R9 cmd_full gated", irq, 0);
    cmd_full = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_demand_pause();
    t_burst();
    t_single();
    t_fifo();
    t_disable_restart();
    t_done_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule